// File: doc/BRIEF.md
# Three-Stage Blocking Stream Chain

This block moves a run of data words through three processing stages. The first stage accepts words from an upstream valid/ready port. The second stage adds a programmable increment to each word. The third stage presents the results on a downstream valid/ready port. Two FIFOs join the stages. Each FIFO has exactly one writer stage and one reader stage. A stage waits whenever the FIFO it writes is full or the FIFO it reads is empty, so back-pressure from the sink travels back to the source without losing any word.

Software-side logic sets a word count and an increment and pulses `start` while the chain is idle. Each of the three stages then handles exactly that many words and goes quiet. When the last result has left the sink port, `done` rises. Each FIFO reports its fill level and its fixed capacity for monitoring.

The FIFO depth is a single parameter. It must be a power of two between 16 and 32768. Any other value stops elaboration.

Top module: `stream_chain3`

## Requirements
- R1: After a synchronous reset, `snk_valid`, `done` and `src_ready` are 0, and both fill levels are 0.
- R2: Every word leaves in arrival order as `src_data + cfg_incr` modulo 2^DW. Every word leaves exactly once, whatever the input gaps or sink stalls.
- R3: After an accepted start, the source port takes exactly `cfg_count` words. `src_ready` then stays 0.
- R4: A blocking write never overfills a FIFO. While the sink is stalled, the chain absorbs exactly 2*DEPTH+2 words (the two FIFOs plus one register in the adder and one in the sink). `src_ready` is then 0.
- R5: While `snk_valid` is 1 and `snk_ready` is 0, `snk_valid` stays 1 and `snk_data` does not change.
- R6: `f0_level` and `f1_level` give the current entry count of each FIFO. The counts return to 0 after a run. `f0_capacity` and `f1_capacity` give DEPTH, which defaults to 32. DEPTH must be a power of two from 16 to 32768, and any other value fails elaboration.
- R7: `done` is 0 from the cycle after an accepted start. It becomes 1 in the cycle after the handshake of the last output word and holds until the next accepted start.
- R8: A start with `cfg_count` = 0 raises `done` in the next cycle. No word is then accepted or produced.
- R9: A `start` pulse while any stage still has work is ignored. The run in progress continues with its original count and increment.
- R10: With the source always valid and the sink always ready, the chain delivers one word per cycle. The first and last output handshakes of an N-word run are N-1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run when the chain is idle |
| cfg_count | input | CW | Number of words in the run |
| cfg_incr | input | DW | Increment added to every word |
| src_valid | input | 1 | Upstream word is present |
| src_data | input | DW | Upstream word |
| src_ready | output | 1 | Source stage takes the word this cycle |
| snk_valid | output | 1 | Result word is present |
| snk_data | output | DW | Result word |
| snk_ready | input | 1 | Downstream takes the result this cycle |
| done | output | 1 | Last word of the run has been delivered |
| f0_level | output | log2(DEPTH)+1 | Entries held in the first FIFO |
| f0_capacity | output | log2(DEPTH)+1 | Capacity of the first FIFO |
| f1_level | output | log2(DEPTH)+1 | Entries held in the second FIFO |
| f1_capacity | output | log2(DEPTH)+1 | Capacity of the second FIFO |

## Verification
A FIFO push and a pop can land in the same cycle, including the case where the entry being written is the one being read next. Input-side acceptance and output-side delivery can also coincide in that cycle. These collisions are provoked in several ways: streaming at full rate, gapping the source with a pseudo-random sink, and starving a nearly empty FIFO. They are judged by comparing every delivered word against a model of input plus increment, in order, and by checking the one-word-per-cycle spacing. A second overlap is a new `start` arriving while a run is still draining. It is judged by confirming that the delivered words keep the original count and increment.

// File: rtl/stream_chain_pkg.sv
package stream_chain_pkg;

  // Legal FIFO depths: a power of two from 16 up to 32768.
  function automatic bit depth_is_legal(int unsigned d);
    return (d >= 16) && (d <= 32768) && ((d & (d - 1)) == 0);
  endfunction

  // Width that holds every count from 0 to d.
  function automatic int unsigned level_width(int unsigned d);
    return $clog2(d) + 1;
  endfunction

endpackage

// File: rtl/sc_pipe_fifo.sv
module sc_pipe_fifo
  import stream_chain_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [DW-1:0]               push_data,
  output logic                        full,
  input  logic                        pop,
  output logic [DW-1:0]               pop_data,
  output logic                        empty,
  output logic [level_width(DEPTH)-1:0] level,
  output logic [level_width(DEPTH)-1:0] capacity
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = level_width(DEPTH);

  generate
    if (!depth_is_legal(DEPTH)) begin : g_bad_depth
      $error("sc_pipe_fifo: DEPTH must be a power of two from 16 to 32768");
    end
  endgenerate

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_addr_nxt;
  logic [LW-1:0] level_q;
  logic [DW-1:0] rd_q;
  logic          do_push, do_pop;

  assign full     = (level_q == LW'(DEPTH));
  assign empty    = (level_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign level    = level_q;
  assign capacity = LW'(DEPTH);
  assign pop_data = rd_q;

  assign rd_addr_nxt = do_pop ? rd_ptr + 1'b1 : rd_ptr;

  // Storage: synchronous write, no reset, so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // Registered read of the next head entry. A word written to that same
  // entry in this cycle is forwarded around the array.
  always_ff @(posedge clk) begin
    if (do_push && (wr_ptr == rd_addr_nxt)) rd_q <= push_data;
    else                                    rd_q <= mem[rd_addr_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_addr_nxt;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  // R4: the writer stage never pushes into a full FIFO
  a_r4_push_not_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R4: the reader stage never pops an empty FIFO
  a_r4_pop_not_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R6: the fill level never passes the capacity
  a_r6_level_cap: assert property (@(posedge clk) disable iff (rst)
    level_q <= LW'(DEPTH));

endmodule

// File: rtl/sc_src_stage.sv
module sc_src_stage #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          q_full,
  output logic          q_push,
  output logic [DW-1:0] q_data,
  output logic          busy
);

  logic [CW-1:0] rem_q;

  assign busy     = (rem_q != '0);
  assign in_ready = busy && !q_full;
  assign q_push   = in_valid && in_ready;
  assign q_data   = in_data;

  always_ff @(posedge clk) begin
    if (rst)         rem_q <= '0;
    else if (load)   rem_q <= load_cnt;
    else if (q_push) rem_q <= rem_q - 1'b1;
  end

endmodule

// File: rtl/sc_add_stage.sv
module sc_add_stage #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic [DW-1:0] load_incr,
  input  logic          in_empty,
  input  logic [DW-1:0] in_data,
  output logic          in_pop,
  input  logic          out_full,
  output logic          out_push,
  output logic [DW-1:0] out_data,
  output logic          busy
);

  logic [CW-1:0] rem_q;
  logic [DW-1:0] incr_q;
  logic [DW-1:0] hold_q;
  logic          hold_v;
  logic          slot_free;

  assign out_push  = hold_v && !out_full;
  assign slot_free = !hold_v || !out_full;
  assign in_pop    = (rem_q != '0) && !in_empty && slot_free;
  assign out_data  = hold_q;
  assign busy      = (rem_q != '0) || hold_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      incr_q <= '0;
      hold_v <= 1'b0;
    end else if (load) begin
      rem_q  <= load_cnt;
      incr_q <= load_incr;
    end else begin
      if (in_pop) begin
        rem_q  <= rem_q - 1'b1;
        hold_v <= 1'b1;
      end else if (out_push) begin
        hold_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_pop) hold_q <= in_data + incr_q;
  end

  // R2: a result blocked by a full FIFO is neither lost nor altered
  a_r2_hold_keep: assert property (@(posedge clk) disable iff (rst)
    (hold_v && out_full) |=> (hold_v && $stable(hold_q)));

endmodule

// File: rtl/sc_snk_stage.sv
module sc_snk_stage #(
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          in_empty,
  input  logic [DW-1:0] in_data,
  output logic          in_pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          done,
  output logic          busy
);

  logic [CW-1:0] rem_q;
  logic          xfer;

  assign busy   = (rem_q != '0);
  assign xfer   = out_valid && out_ready;
  assign in_pop = busy && !in_empty && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q     <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else if (load) begin
      rem_q <= load_cnt;
      done  <= (load_cnt == '0);
    end else begin
      if (in_pop)    out_valid <= 1'b1;
      else if (xfer) out_valid <= 1'b0;
      if (xfer) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CW'(1)) done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_pop) out_data <= in_data;
  end

  // R5: a stalled output holds its word
  a_r5_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: done only rises after the final handshake or an empty run
  a_r7_done_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(xfer) || $past(load)));

endmodule

// File: rtl/stream_chain3.sv
module stream_chain3
  import stream_chain_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CW-1:0]        cfg_count,
  input  logic [DW-1:0]        cfg_incr,
  input  logic                 src_valid,
  input  logic [DW-1:0]        src_data,
  output logic                 src_ready,
  output logic                 snk_valid,
  output logic [DW-1:0]        snk_data,
  input  logic                 snk_ready,
  output logic                 done,
  output logic [$clog2(DEPTH):0] f0_level,
  output logic [$clog2(DEPTH):0] f0_capacity,
  output logic [$clog2(DEPTH):0] f1_level,
  output logic [$clog2(DEPTH):0] f1_capacity
);

  logic          src_busy, add_busy, snk_busy, running, go;
  logic          f0_push, f0_full, f0_pop, f0_empty;
  logic          f1_push, f1_full, f1_pop, f1_empty;
  logic [DW-1:0] f0_wdata, f0_rdata, f1_wdata, f1_rdata;

  assign running = src_busy || add_busy || snk_busy;
  assign go      = start && !running;

  sc_src_stage #(.DW(DW), .CW(CW)) u_src (
    .clk(clk), .rst(rst), .load(go), .load_cnt(cfg_count),
    .in_valid(src_valid), .in_data(src_data), .in_ready(src_ready),
    .q_full(f0_full), .q_push(f0_push), .q_data(f0_wdata), .busy(src_busy)
  );

  sc_pipe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo0 (
    .clk(clk), .rst(rst), .push(f0_push), .push_data(f0_wdata), .full(f0_full),
    .pop(f0_pop), .pop_data(f0_rdata), .empty(f0_empty),
    .level(f0_level), .capacity(f0_capacity)
  );

  sc_add_stage #(.DW(DW), .CW(CW)) u_add (
    .clk(clk), .rst(rst), .load(go), .load_cnt(cfg_count), .load_incr(cfg_incr),
    .in_empty(f0_empty), .in_data(f0_rdata), .in_pop(f0_pop),
    .out_full(f1_full), .out_push(f1_push), .out_data(f1_wdata), .busy(add_busy)
  );

  sc_pipe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo1 (
    .clk(clk), .rst(rst), .push(f1_push), .push_data(f1_wdata), .full(f1_full),
    .pop(f1_pop), .pop_data(f1_rdata), .empty(f1_empty),
    .level(f1_level), .capacity(f1_capacity)
  );

  sc_snk_stage #(.DW(DW), .CW(CW)) u_snk (
    .clk(clk), .rst(rst), .load(go), .load_cnt(cfg_count),
    .in_empty(f1_empty), .in_data(f1_rdata), .in_pop(f1_pop),
    .out_valid(snk_valid), .out_data(snk_data), .out_ready(snk_ready),
    .done(done), .busy(snk_busy)
  );

  // R7: a finished chain is quiet at both ports
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> (!snk_valid && !src_ready));

  // R9: a start during a run does not reset the sink's progress
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && running && !done) |=> !done || $past(snk_valid && snk_ready));

endmodule

// File: tb/stream_chain3_test.sv
module stream_chain3_test;

  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int CW = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  typedef struct packed {
    logic [15:0] cnt;
    logic [31:0] incr;
    logic [31:0] seed;
    logic [1:0]  mode;
    logic        inject;
    logic        fill;
  } run_t;

  localparam int NRUNS = 6;
  localparam run_t RUNS [NRUNS] = '{
    '{16'd40,  32'd5,         32'h0000_0010, 2'd0, 1'b0, 1'b0},
    '{16'd70,  32'hFFFF_FFFF, 32'h0000_0100, 2'd1, 1'b1, 1'b0},
    '{16'd1,   32'd7,         32'hFFFF_FFFE, 2'd0, 1'b0, 1'b0},
    '{16'd90,  32'h0000_1234, 32'h0000_0ABC, 2'd2, 1'b0, 1'b0},
    '{16'd33,  32'd1,         32'h0000_0000, 2'd3, 1'b0, 1'b0},
    '{16'd100, 32'd2,         32'h0000_0500, 2'd0, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [CW-1:0] cfg_count;
  logic [DW-1:0] cfg_incr;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_ready;
  logic          snk_valid;
  logic [DW-1:0] snk_data;
  logic          snk_ready;
  logic          done;
  logic [LW-1:0] f0_level, f0_capacity, f1_level, f1_capacity;

  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  stream_chain3 #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) uut (
    .clk(clk), .rst(rst), .start(start), .cfg_count(cfg_count), .cfg_incr(cfg_incr),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .done(done), .f0_level(f0_level), .f0_capacity(f0_capacity),
    .f1_level(f1_level), .f1_capacity(f1_capacity)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input logic [31:0] seed, input int i);
    return seed + 32'(i) * 32'h0001_0003;
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic launch(input logic [15:0] cnt, input logic [31:0] incr);
    @(negedge clk);
    cfg_count = cnt;
    cfg_incr  = incr;
    start     = 1'b1;
    src_valid = 1'b0;
    snk_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_run(input run_t r);
    int  sent = 0;
    int  got = 0;
    int  first_cyc = -1;
    int  last_cyc = -1;
    bit  fin = 1'b0;
    launch(r.cnt, r.incr);
    #1;
    check(done == 1'b0, "R7 done cleared after start", 64'(done), 64'd0);
    if (r.fill) begin
      // Sink stalled: fill the whole chain
      for (int c = 0; c < 150; c++) begin
        src_valid = (sent < int'(r.cnt));
        src_data  = word_at(r.seed, sent);
        snk_ready = 1'b0;
        #1;
        if (src_valid && src_ready) sent++;
        @(negedge clk);
      end
      #1;
      check(src_ready == 1'b0, "R4 source blocked when chain full", 64'(src_ready), 64'd0);
      check(sent == 2 * DEPTH + 2, "R4 words absorbed under stall", 64'(sent), 64'(2 * DEPTH + 2));
      check(f0_level == LW'(DEPTH), "R6 first FIFO level full", 64'(f0_level), 64'(DEPTH));
      check(f1_level == LW'(DEPTH), "R6 second FIFO level full", 64'(f1_level), 64'(DEPTH));
      for (int c = 0; c < 4; c++) begin
        check(snk_valid == 1'b1 && snk_data == word_at(r.seed, 0) + r.incr,
              "R5 stalled output held", 64'(snk_data), 64'(word_at(r.seed, 0) + r.incr));
        @(negedge clk);
        #1;
      end
    end
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      step_lfsr();
      start = r.inject && (cyc == 6);
      if (start) begin
        cfg_count = 16'd3;
        cfg_incr  = 32'd999;
      end
      case (r.mode)
        2'd0: begin src_valid = 1'b1;          snk_ready = 1'b1; end
        2'd1: begin src_valid = lfsr[0];       snk_ready = lfsr[3] | lfsr[7]; end
        2'd2: begin src_valid = 1'b1;          snk_ready = (cyc % 4 == 0); end
        default: begin src_valid = (cyc % 3 != 0); snk_ready = 1'b1; end
      endcase
      if (sent >= int'(r.cnt)) src_valid = 1'b1;
      src_data = word_at(r.seed, sent);
      #1;
      if (sent >= int'(r.cnt) && sent > 0)
        check(src_ready == 1'b0, "R3 no acceptance past count", 64'(src_ready), 64'd0);
      if (src_valid && src_ready) sent++;
      if (snk_valid && snk_ready) begin
        check(snk_data == word_at(r.seed, got) + r.incr, "R2 R9 output word",
              64'(snk_data), 64'(word_at(r.seed, got) + r.incr));
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        got++;
        if (got == int'(r.cnt)) begin
          check(done == 1'b0, "R7 done low before last handshake", 64'(done), 64'd0);
          @(negedge clk);
          start = 1'b0;
          #1;
          check(done == 1'b1, "R7 done after last handshake", 64'(done), 64'd1);
          fin = 1'b1;
        end
      end
      if (!fin) @(negedge clk);
    end
    start = 1'b0;
    src_valid = 1'b1;
    snk_ready = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(got == int'(r.cnt), "R2 output word count", 64'(got), 64'(r.cnt));
    check(sent == int'(r.cnt), "R3 input word count", 64'(sent), 64'(r.cnt));
    check(src_ready == 1'b0 && snk_valid == 1'b0, "R3 ports idle after run",
          64'({src_ready, snk_valid}), 64'd0);
    check(done == 1'b1, "R7 done holds", 64'(done), 64'd1);
    check(f0_level == '0 && f1_level == '0, "R6 levels drained",
          64'({f0_level, f1_level}), 64'd0);
    if (r.mode == 2'd0 && !r.fill)
      check(last_cyc - first_cyc == int'(r.cnt) - 1, "R10 one word per cycle",
            64'(last_cyc - first_cyc), 64'(int'(r.cnt) - 1));
    src_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    start = 1'b0;
    cfg_count = '0;
    cfg_incr = '0;
    src_valid = 1'b0;
    src_data = '0;
    snk_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    check(snk_valid == 1'b0, "R1 snk_valid after reset", 64'(snk_valid), 64'd0);
    check(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    check(src_ready == 1'b0, "R1 src_ready after reset", 64'(src_ready), 64'd0);
    check(f0_level == '0 && f1_level == '0, "R1 levels after reset",
          64'({f0_level, f1_level}), 64'd0);
    check(f0_capacity == LW'(DEPTH) && f1_capacity == LW'(DEPTH), "R6 capacity",
          64'({f0_capacity, f1_capacity}), 64'({LW'(DEPTH), LW'(DEPTH)}));

    for (int i = 0; i < NRUNS; i++) do_run(RUNS[i]);

    // R8: empty run
    launch(16'd0, 32'd3);
    src_valid = 1'b1;
    snk_ready = 1'b1;
    #1;
    check(done == 1'b1, "R8 done after empty start", 64'(done), 64'd1);
    check(src_ready == 1'b0, "R8 no input accepted", 64'(src_ready), 64'd0);
    repeat (3) @(negedge clk);
    #1;
    check(snk_valid == 1'b0, "R8 no output produced", 64'(snk_valid), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule